// File: doc/BRIEF.md
# Priority-Chained Interrupt Acknowledge

This block collects interrupt requests from a row of device slices and presents them to a processor as one request line. When the processor answers with an acknowledge, that acknowledge enters the slice nearest the processor and ripples down the row. Each slice forwards it only if it is not requesting itself. The first requesting slice it meets keeps the acknowledge and takes the shared vector bus, so priority follows physical position and no central encoder is needed.

Request and acknowledge follow a four-phase handshake. First a request goes up. Then the acknowledge goes up, and the winning slice is latched. The winner then withdraws its request once its vector has been taken. Last, the acknowledge goes down, which releases the bus. Because the winner is captured only on the clock edge where the acknowledge is first seen high, requests that appear later in the same cycle do not disturb the vector on the bus. When the acknowledge leaves the end of the row unclaimed, a separate output reports it.

Top module: `irq_daisy_chain`

## Requirements
- R1: `intr` is high in the same cycle as any bit of `dev_req` is high, and low when all of `dev_req` are low.
- R2: The slice at index 0 has the highest priority, and priority falls as the index rises. The winner of an acknowledge is the lowest index whose `dev_req` bit is set.
- R3: `ack_tail` is high exactly when `inta` is high and no bit of `dev_req` is set. A requesting slice stops the acknowledge from reaching any slice after it.
- R4: The winner is captured on the first rising clock edge at which `inta` is sampled high after having been sampled low. From the next cycle on, `drive_en` has only the winner's bit set and `vec_valid` is high.
- R5: While `inta` stays high after the capture, changes on `dev_req` leave `drive_en`, `vec_bus` and `vec_valid` unchanged. This includes new requests of higher priority.
- R6: At the first rising edge at which `inta` is sampled low, the winner is released. After that edge `drive_en` is all zero, `vec_bus` is zero and `vec_valid` is low.
- R7: If no request is pending at the capturing edge, `vec_valid` stays low and `vec_bus` reads zero for the rest of that acknowledge.
- R8: Following a synchronous active-low reset, `drive_en` is zero, `vec_bus` is zero and `vec_valid` is low.
- R9: At most one bit of `drive_en` is ever set.
- R10: The vector of slice i is `VEC_OFFSET + i`. With the default offset of zero this is the slice index. `vec_bus` carries the vector of the driving slice, and is zero when no slice drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | N_DEV | Per-slice interrupt request, bit 0 is highest priority |
| inta | input | 1 | Acknowledge from the processor |
| intr | output | 1 | Combined interrupt request to the processor |
| ack_tail | output | 1 | Acknowledge that passed every slice unclaimed |
| drive_en | output | N_DEV | Per-slice enable for driving the vector bus |
| vec_bus | output | VEC_W | Vector of the winning slice, zero when none drives |
| vec_valid | output | 1 | A slice is driving the vector bus |

## Verification
The bench tries request patterns that have one requester, several requesters, the last slice alone, and every slice at once. A chain that ripples in the wrong direction, or that lets the acknowledge leak past a requester, would put the wrong vector on the bus or light two enables. The bench also raises a request of higher priority while the acknowledge is held high, and it raises an acknowledge with no request and then adds one. A design that captures continuously instead of on the rising edge would change the vector in the middle of a cycle. Finally, the bench drops the acknowledge and checks that the bus is freed on the very next edge, and that the tail output tracks the absence of requests.

// File: rtl/irq_chain_pkg.sv
// Package: shared helpers for the interrupt acknowledge chain.
// Assumes vector widths are wide enough for offset plus slice count.
package irq_chain_pkg;

    // Vector value assigned to a slice: a base offset plus its position.
    function automatic int vec_for_slot(input int offset, input int idx);
        return offset + idx;
    endfunction

endpackage

// File: rtl/irq_req_or.sv
// Module: irq_req_or
// Combines all per-slice requests into the single processor request.
// Assumes requests are already synchronous to clk.
module irq_req_or #(
    parameter int N_DEV = 8
) (
    input  logic [N_DEV-1:0] req,
    output logic             any_req
);

    // Reduction OR of every local request.
    always_comb begin
        any_req = |req;
    end

endmodule

// File: rtl/irq_chain_slice.sv
// Module: irq_chain_slice
// One device interface in the acknowledge chain. It forwards the
// acknowledge only when idle, and latches itself as the winner on the
// capture pulse. It holds the win until the acknowledge level drops.
// Assumes ack_start is a single-cycle pulse at the start of an acknowledge.
module irq_chain_slice #(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] SLOT_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ack_in,
    input  logic             ack_start,
    input  logic             ack_level,
    output logic             ack_out,
    output logic             drive,
    output logic [VEC_W-1:0] vec_out
);

    logic won;

    // Pass the acknowledge down only when this slice is not requesting.
    always_comb begin
        ack_out = ack_in & ~req;
    end

    // Capture the win on the acknowledge start and release it when the acknowledge falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            won <= 1'b0;
        end else if (!ack_level) begin
            won <= 1'b0;
        end else if (ack_start) begin
            won <= ack_in & req;
        end
    end

    // Present the enable and the gated constant vector.
    always_comb begin
        drive   = won;
        vec_out = won ? SLOT_VEC : '0;
    end

endmodule

// File: rtl/irq_vec_merge.sv
// Module: irq_vec_merge
// Models the shared vector bus: ORs the gated vectors of all slices.
// An undriven bus reads as zero. Assumes at most one slice drives.
module irq_vec_merge #(
    parameter int N_DEV = 8,
    parameter int VEC_W = 8
) (
    input  logic [N_DEV*VEC_W-1:0] vec_flat,
    input  logic [N_DEV-1:0]       en,
    output logic [VEC_W-1:0]       bus,
    output logic                   valid
);

    // Wired-OR of the already gated slice vectors.
    always_comb begin
        bus = '0;
        for (int i = 0; i < N_DEV; i++) begin
            bus = bus | vec_flat[i*VEC_W +: VEC_W];
        end
    end

    // The bus is valid whenever any slice holds its enable.
    always_comb begin
        valid = |en;
    end

endmodule

// File: rtl/irq_daisy_chain.sv
// Module: irq_daisy_chain (top)
// A row of N_DEV slices that share one request line and settle priority
// by rippling the acknowledge from slice 0 toward slice N_DEV-1.
// Assumes inta is synchronous to clk and follows the four-phase handshake.
module irq_daisy_chain #(
    parameter int N_DEV      = 8,
    parameter int VEC_W      = 8,
    parameter int VEC_OFFSET = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    input  logic             inta,
    output logic             intr,
    output logic             ack_tail,
    output logic [N_DEV-1:0] drive_en,
    output logic [VEC_W-1:0] vec_bus,
    output logic             vec_valid
);

    localparam int FLAT_W = N_DEV * VEC_W;

    logic              inta_q;
    logic              ack_start;
    logic [N_DEV:0]    ack_link;
    logic [FLAT_W-1:0] vec_flat;

    // Remember the previous acknowledge level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inta_q <= 1'b0;
        end else begin
            inta_q <= inta;
        end
    end

    // Single-cycle capture pulse at the start of an acknowledge.
    always_comb begin
        ack_start = inta & ~inta_q;
    end

    irq_req_or #(.N_DEV(N_DEV)) u_req_or (
        .req     (dev_req),
        .any_req (intr)
    );

    assign ack_link[0] = inta;

    // One slice for each device, linked in priority order.
    for (genvar i = 0; i < N_DEV; i++) begin : g_slice
        irq_chain_slice #(
            .VEC_W    (VEC_W),
            .SLOT_VEC (VEC_W'(irq_chain_pkg::vec_for_slot(VEC_OFFSET, i)))
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (dev_req[i]),
            .ack_in    (ack_link[i]),
            .ack_start (ack_start),
            .ack_level (inta),
            .ack_out   (ack_link[i+1]),
            .drive     (drive_en[i]),
            .vec_out   (vec_flat[i*VEC_W +: VEC_W])
        );
    end

    assign ack_tail = ack_link[N_DEV];

    irq_vec_merge #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_merge (
        .vec_flat (vec_flat),
        .en       (drive_en),
        .bus      (vec_bus),
        .valid    (vec_valid)
    );

endmodule

// File: rtl/irq_daisy_chain_checker.sv
// Module: irq_daisy_chain_checker
// Protocol and ownership properties of the acknowledge chain, observed
// at the top-level ports. Keeps its own record of the acknowledge level.
module irq_daisy_chain_checker #(
    parameter int N_DEV = 8,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEV-1:0] dev_req,
    input logic             inta,
    input logic             intr,
    input logic             ack_tail,
    input logic [N_DEV-1:0] drive_en,
    input logic [VEC_W-1:0] vec_bus,
    input logic             vec_valid
);

    logic seen_ack;

    // Acknowledge level seen at the previous edge, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_ack <= 1'b0;
        else        seen_ack <= inta;
    end

    assert_req_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req != '0) |-> intr);

    assert_tail_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_tail |-> (inta && dev_req == '0));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !seen_ack && dev_req != '0) |=> vec_valid);

    assert_hold_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && seen_ack) |=> ($stable(drive_en) && $stable(vec_bus)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> (!vec_valid && vec_bus == '0));

    assert_idle_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !seen_ack && dev_req == '0) |=> !vec_valid);

    assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_en));

endmodule

bind irq_daisy_chain irq_daisy_chain_checker #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .inta      (inta),
    .intr      (intr),
    .ack_tail  (ack_tail),
    .drive_en  (drive_en),
    .vec_bus   (vec_bus),
    .vec_valid (vec_valid)
);

// File: tb/irq_daisy_chain_bench.sv
`timescale 1ns/1ps
// Directed bench for the interrupt acknowledge chain.
module irq_daisy_chain_bench;

    localparam int N   = 6;
    localparam int W   = 8;
    localparam int OFS = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] dev_req;
    logic         inta;
    logic         intr;
    logic         ack_tail;
    logic [N-1:0] drive_en;
    logic [W-1:0] vec_bus;
    logic         vec_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_daisy_chain #(.N_DEV(N), .VEC_W(W), .VEC_OFFSET(OFS)) u_irq_daisy_chain (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .inta(inta),
        .intr(intr), .ack_tail(ack_tail), .drive_en(drive_en),
        .vec_bus(vec_bus), .vec_valid(vec_valid)
    );

    // Compare one value and record the result.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: through the rising edge to the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Lowest set index, or -1 when none.
    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    // Check the bus outputs against an expected winner (-1 = none).
    task automatic check_owner(input string req, input int idx);
        check({req, " drive_en"}, int'(drive_en), idx < 0 ? 0 : (1 << idx));
        check({req, " vec_bus"},  int'(vec_bus),  idx < 0 ? 0 : OFS + idx);
        check({req, " vec_valid"}, int'(vec_valid), idx < 0 ? 0 : 1);
        check("R9 onehot", int'($countones(drive_en) <= 1), 1);
    endtask

    // Reset state check.
    task automatic t_reset();
        rst_n = 1'b0; dev_req = '0; inta = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check_owner("R8 reset", -1);
        check("R1 idle intr", int'(intr), 0);
    endtask

    // Request merge at several patterns.
    task automatic t_intr_or();
        logic [N-1:0] pats [4] = '{6'b000001, 6'b100000, 6'b010100, 6'b000000};
        foreach (pats[k]) begin
            dev_req = pats[k];
            #1;
            check("R1 intr", int'(intr), pats[k] != 0);
        end
    endtask

    // Tail output versus requests while the acknowledge is high.
    task automatic t_tail();
        dev_req = '0; inta = 1'b1;
        #1;
        check("R3 tail idle", int'(ack_tail), 1);
        dev_req = 6'b100000;
        #1;
        check("R3 tail blocked", int'(ack_tail), 0);
        inta = 1'b0; dev_req = '0;
        tick();
        check("R3 tail no ack", int'(ack_tail), 0);
    endtask

    // Full handshake for one request pattern.
    task automatic t_ack(input logic [N-1:0] pat);
        int win;
        win = lowest(pat);
        dev_req = pat;
        tick();
        inta = 1'b1;
        tick();
        check_owner("R2 R4 R10 winner", win);
        dev_req[win] = 1'b0;
        tick();
        check_owner("R5 after drop", win);
        inta = 1'b0;
        tick();
        check_owner("R6 release", -1);
        dev_req = '0;
        tick();
    endtask

    // Higher-priority request during a held acknowledge.
    task automatic t_late_request();
        dev_req = 6'b001000;
        tick();
        inta = 1'b1;
        tick();
        check_owner("R4 capture", 3);
        dev_req = 6'b001001;
        tick(); tick();
        check_owner("R5 late higher request", 3);
        inta = 1'b0; dev_req = '0;
        tick();
        check_owner("R6 release", -1);
    endtask

    // Acknowledge with nothing pending, then a request arrives.
    task automatic t_empty_ack();
        dev_req = '0;
        tick();
        inta = 1'b1;
        tick();
        check_owner("R7 empty capture", -1);
        dev_req = 6'b000010;
        tick(); tick();
        check_owner("R7 R5 request after empty capture", -1);
        inta = 1'b0;
        tick();
        inta = 1'b1;
        tick();
        check_owner("R4 next cycle capture", 1);
        inta = 1'b0; dev_req = '0;
        tick();
        check_owner("R6 release", -1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_intr_or();
        t_tail();
        t_ack(6'b000001);
        t_ack(6'b101000);
        t_ack(6'b100000);
        t_ack(6'b111111);
        t_late_request();
        t_empty_ack();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule